// File: doc/BRIEF.md
# NAND Read-Path Hamming Check and Correct

This block sits on the read path of a NAND flash controller, after a hardware line-parity generator has digested one ECC block of page data. It takes the raw 32-bit parity word that the generator produced, folds it into a 24-bit code and inverts it. An erased page of all-ones data therefore yields a code that agrees with an erased, all-ones spare area. The same folded code is presented as three bytes, low byte first, for the write path to store in the spare area.

On a read, the 24-bit code fetched from the spare area arrives together with the raw parity word. The block forms the syndrome of the two codes and classifies it into one of four outcomes: clean, a correctable single-bit data error, a single-bit error in the stored code itself, or an uncorrectable error. For a correctable error it reports the byte offset inside the ECC block and a one-hot mask of the bit to flip. Software or a downstream buffer applies that mask to the data. The block neither computes the line parity nor holds any page data.

Inputs are accepted under a valid/ready handshake. Each accepted pair yields exactly one result, two cycles later, marked by a one-cycle output valid.

Top module: `nand_ecc_fixer`

## Requirements
- R1: The fresh code keeps bits 11:0 of the raw parity word at code bits 11:0 and moves raw bits 27:16 down to code bits 23:12, then inverts all 24 bits. Raw bits 31:28 and 15:12 have no effect on any output.
- R2: A raw parity word of zero gives the code 0xFFFFFF, so an erased spare area reading 0xFFFFFF classifies as clean.
- R3: The code is output as three bytes, aligned with the result: codeByte0 carries code bits 7:0, codeByte1 bits 15:8 and codeByte2 bits 23:16.
- R4: The syndrome is the fresh code XOR the read code. A zero syndrome gives status 0 (clean).
- R5: When syndrome[23:12] XOR syndrome[11:0] equals 0xFFF and syndrome[23:15] is below BLOCK_BYTES, the status is 1 (corrected). The offset output is syndrome[23:15] and the mask output is 1 shifted left by syndrome[14:12].
- R6: When the halves are complementary but syndrome[23:15] is not below BLOCK_BYTES, the status is 3 (uncorrectable).
- R7: A syndrome with exactly one bit set gives status 2 (error in the stored code). No data bit is flagged for correction.
- R8: Every other nonzero syndrome gives status 3 (uncorrectable).
- R9: inReady is low in reset and high from the first clock after reset. An input accepted at a clock edge raises outValid for one cycle after the second following edge. Accepted inputs may arrive on every cycle, and results come out in order.
- R10: The offset and mask outputs are zero whenever the status is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pair is valid |
| inReady | output | 1 | Block accepts an input this cycle |
| rawParity | input | 32 | Raw parity word from the line-parity generator |
| readCode | input | 24 | Code read back from the spare area |
| outValid | output | 1 | Result valid for this cycle |
| outStatus | output | 2 | 0 clean, 1 corrected, 2 code error, 3 uncorrectable |
| outOffset | output | 9 | Byte offset of the bit to flip |
| outMask | output | 8 | One-hot mask of the bit to flip |
| codeByte0 | output | 8 | Fresh code bits 7:0 |
| codeByte1 | output | 8 | Fresh code bits 15:8 |
| codeByte2 | output | 8 | Fresh code bits 23:16 |

## Verification
The bench targets the edges of classification. It uses correctable syndromes at the first and last in-range offset, and the first offset past the block size, which the bench instance lowers so that an off-by-one range test shows up as a wrong status. Single-bit syndromes are placed at bit 0, bit 12 and bit 23, next to two-bit and all-ones syndromes. A design that used the wrong single-bit test or the wrong order of tests would then report a code error as corrected or uncorrectable. Raw words with the reserved nibbles set catch packing that leaks those bits. Back-to-back inputs catch a valid pipeline that drops or duplicates results.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_CODE  = 2'd2,
    ST_BAD   = 2'd3
  } eccStatus_t;

  typedef struct packed {
    logic loadStage1;
    logic loadStage2;
  } eccStrobe_t;

endpackage

// File: rtl/ecc_fix_ctrl.sv
module ecc_fix_ctrl
  import nand_ecc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output eccStrobe_t strobe,
  output logic       outValid
);

  logic readyR;
  logic stage1V;
  logic stage2V;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyR  <= 1'b0;
      stage1V <= 1'b0;
      stage2V <= 1'b0;
    end else begin
      readyR  <= 1'b1;
      stage1V <= inValid & readyR;
      stage2V <= stage1V;
    end
  end

  always_comb begin
    strobe.loadStage1 = inValid & readyR;
    strobe.loadStage2 = stage1V;
  end

  assign inReady  = readyR;
  assign outValid = stage2V;

endmodule

// File: rtl/ecc_fix_datapath.sv
module ecc_fix_datapath
  import nand_ecc_pkg::*;
#(
  parameter int RAW_W       = 32,
  parameter int HALF_W      = 12,
  parameter int BIT_W       = 3,
  parameter int BLOCK_BYTES = 512,
  localparam int CODE_W     = 2 * HALF_W,
  localparam int OFF_W      = HALF_W - BIT_W,
  localparam int MASK_W     = 1 << BIT_W,
  localparam int UPPER_BASE = RAW_W / 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  eccStrobe_t        strobe,
  input  logic [RAW_W-1:0]  rawParity,
  input  logic [CODE_W-1:0] readCode,
  output logic [1:0]        resStatus,
  output logic [OFF_W-1:0]  resOffset,
  output logic [MASK_W-1:0] resMask,
  output logic [CODE_W-1:0] resCode
);

  // stage 1: fold, invert, syndrome, half tests
  logic [CODE_W-1:0] packedWord;
  logic [CODE_W-1:0] freshCode;
  logic [CODE_W-1:0] syndrome;
  logic [CODE_W-1:0] synMinusOne;
  logic              synZero;
  logic              synSingle;
  logic              halvesCompl;

  always_comb begin
    for (int i = 0; i < HALF_W; i++) begin
      packedWord[i]          = rawParity[i];
      packedWord[HALF_W + i] = rawParity[UPPER_BASE + i];
    end
    freshCode   = ~packedWord;
    syndrome    = freshCode ^ readCode;
    synMinusOne = syndrome - CODE_W'(1);
    synZero     = (syndrome == '0);
    synSingle   = !synZero && ((syndrome & synMinusOne) == '0);
    halvesCompl = ((syndrome[CODE_W-1:HALF_W] ^ syndrome[HALF_W-1:0]) == {HALF_W{1'b1}});
  end

  logic [CODE_W-1:0] codeR;
  logic [CODE_W-1:0] synR;
  logic              zeroR;
  logic              singleR;
  logic              complR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeR   <= '0;
      synR    <= '0;
      zeroR   <= 1'b1;
      singleR <= 1'b0;
      complR  <= 1'b0;
    end else if (strobe.loadStage1) begin
      codeR   <= freshCode;
      synR    <= syndrome;
      zeroR   <= synZero;
      singleR <= synSingle;
      complR  <= halvesCompl;
    end
  end

  // stage 2: classify and locate
  logic [OFF_W-1:0]  offField;
  logic [BIT_W-1:0]  bitField;
  logic              inRange;
  eccStatus_t        nextStatus;
  logic [OFF_W-1:0]  nextOffset;
  logic [MASK_W-1:0] nextMask;

  always_comb begin
    offField   = synR[CODE_W-1 -: OFF_W];
    bitField   = synR[HALF_W +: BIT_W];
    inRange    = (32'(offField) < BLOCK_BYTES);
    nextStatus = ST_BAD;
    nextOffset = '0;
    nextMask   = '0;
    if (zeroR) begin
      nextStatus = ST_CLEAN;
    end else if (complR) begin
      if (inRange) begin
        nextStatus = ST_FIXED;
        nextOffset = offField;
        nextMask   = MASK_W'(1) << bitField;
      end else begin
        nextStatus = ST_BAD;
      end
    end else if (singleR) begin
      nextStatus = ST_CODE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resStatus <= ST_CLEAN;
      resOffset <= '0;
      resMask   <= '0;
      resCode   <= '0;
    end else if (strobe.loadStage2) begin
      resStatus <= nextStatus;
      resOffset <= nextOffset;
      resMask   <= nextMask;
      resCode   <= codeR;
    end
  end

endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
  import nand_ecc_pkg::*;
#(
  parameter int RAW_W       = 32,
  parameter int HALF_W      = 12,
  parameter int BIT_W       = 3,
  parameter int BLOCK_BYTES = 512,
  localparam int CODE_W     = 2 * HALF_W,
  localparam int OFF_W      = HALF_W - BIT_W,
  localparam int MASK_W     = 1 << BIT_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [RAW_W-1:0]  rawParity,
  input  logic [CODE_W-1:0] readCode,
  output logic              outValid,
  output logic [1:0]        outStatus,
  output logic [OFF_W-1:0]  outOffset,
  output logic [MASK_W-1:0] outMask,
  output logic [7:0]        codeByte0,
  output logic [7:0]        codeByte1,
  output logic [7:0]        codeByte2
);

  eccStrobe_t        strobe;
  logic [CODE_W-1:0] resCode;

  ecc_fix_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .strobe   (strobe),
    .outValid (outValid)
  );

  ecc_fix_datapath #(
    .RAW_W       (RAW_W),
    .HALF_W      (HALF_W),
    .BIT_W       (BIT_W),
    .BLOCK_BYTES (BLOCK_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rawParity (rawParity),
    .readCode  (readCode),
    .resStatus (outStatus),
    .resOffset (outOffset),
    .resMask   (outMask),
    .resCode   (resCode)
  );

  assign codeByte0 = resCode[7:0];
  assign codeByte1 = resCode[15:8];
  assign codeByte2 = resCode[23:16];

endmodule

// File: rtl/nand_ecc_fixer_chk.sv
module nand_ecc_fixer_chk #(
  parameter int BLOCK_BYTES = 512
)(
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic       outValid,
  input logic [1:0] outStatus,
  input logic [8:0] outOffset,
  input logic [7:0] outMask
);

  AST_FIX_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus == 2'd1) |-> ($countones(outMask) == 1)); // R5

  AST_FIX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus == 2'd1) |-> (32'(outOffset) < BLOCK_BYTES)); // R6

  AST_NOFIX_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outStatus != 2'd1) |-> (outMask == 8'd0 && outOffset == 9'd0)); // R10

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> ##2 outValid); // R9

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid && inReady, 2)); // R9

  AST_READY_UP: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> inReady); // R9

endmodule

bind nand_ecc_fixer nand_ecc_fixer_chk #(.BLOCK_BYTES(BLOCK_BYTES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .outValid  (outValid),
  .outStatus (outStatus),
  .outOffset (outOffset),
  .outMask   (outMask)
);

// File: tb/nand_ecc_fixer_bench.sv
module nand_ecc_fixer_bench;

  localparam int BLK = 384;

  typedef struct {
    logic [1:0]  status;
    logic [8:0]  offset;
    logic [7:0]  mask;
    logic [23:0] code;
    string       tag;
  } expT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] rawParity = '0;
  logic [23:0] readCode = '0;
  logic        outValid;
  logic [1:0]  outStatus;
  logic [8:0]  outOffset;
  logic [7:0]  outMask;
  logic [7:0]  codeByte0, codeByte1, codeByte2;

  int total = 0;
  int bad = 0;
  int produced = 0;
  int sent = 0;
  bit finished = 1'b0;
  expT sb[$];

  always #5 clk = ~clk;

  nand_ecc_fixer #(.BLOCK_BYTES(BLK)) u_nand_ecc_fixer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .rawParity(rawParity), .readCode(readCode), .outValid(outValid),
    .outStatus(outStatus), .outOffset(outOffset), .outMask(outMask),
    .codeByte0(codeByte0), .codeByte1(codeByte1), .codeByte2(codeByte2)
  );

  function automatic logic [23:0] foldCode(logic [31:0] raw);
    return ~{raw[27:16], raw[11:0]};
  endfunction

  function automatic logic [23:0] corrSyn(int off, int bitIdx);
    logic [11:0] hi;
    hi = {off[8:0], bitIdx[2:0]};
    return {hi, ~hi};
  endfunction

  function automatic expT model(logic [31:0] raw, logic [23:0] rd);
    expT e;
    logic [23:0] syn;
    e.code = foldCode(raw);
    syn = e.code ^ rd;
    e.offset = '0;
    e.mask = '0;
    if (syn == 24'd0) begin
      e.status = 2'd0; e.tag = "R4";
    end else if ((syn[23:12] ^ syn[11:0]) == 12'hFFF) begin
      if (int'(syn[23:15]) < BLK) begin
        e.status = 2'd1; e.offset = syn[23:15];
        e.mask = 8'd1 << syn[14:12]; e.tag = "R5";
      end else begin
        e.status = 2'd3; e.tag = "R6";
      end
    end else if ($countones(syn) == 1) begin
      e.status = 2'd2; e.tag = "R7";
    end else begin
      e.status = 2'd3; e.tag = "R8";
    end
    return e;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one item per call, gap idle cycles after it
  task automatic sendItem(logic [31:0] raw, logic [23:0] syn, int gap);
    expT e;
    logic [23:0] rd;
    rd = foldCode(raw) ^ syn;
    e = model(raw, rd);
    sb.push_back(e);
    rawParity = raw;
    readCode  = rd;
    inValid   = 1'b1;
    sent++;
    @(negedge clk);
    inValid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      produced++;
      if (sb.size() == 0) begin
        check("R9 unexpected result", 64'd1, 64'd0);
      end else begin
        expT e;
        e = sb.pop_front();
        check({e.tag, " status"}, 64'(outStatus), 64'(e.status));
        check({e.tag, " R10 offset"}, 64'(outOffset), 64'(e.offset));
        check({e.tag, " R10 mask"}, 64'(outMask), 64'(e.mask));
        check("R3 code bytes", 64'({codeByte2, codeByte1, codeByte0}), 64'(e.code));
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 ready low in reset", 64'(inReady), 64'd0);
    check("R9 no valid in reset", 64'(outValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 ready after reset", 64'(inReady), 64'd1);
    check("R4 reset status", 64'(outStatus), 64'd0);
    @(negedge clk);

    // R2 erased page
    sendItem(32'h0, 24'h0, 2);
    check("R2 erased code", 64'(foldCode(32'h0)), 64'hFFFFFF);
    // R1 reserved nibbles ignored
    sendItem(32'hF000_F000, 24'h0, 1);
    sendItem(32'h1234_5678, 24'h0, 0);
    sendItem(32'hA9CB_3DEF, 24'h0, 0);
    // R5 correctable at edges
    sendItem(32'h0BAD_0C0D, corrSyn(0, 0), 0);
    sendItem(32'h0000_0001, corrSyn(BLK - 1, 7), 1);
    sendItem(32'h5555_AAAA, corrSyn(200, 3), 0);
    // R6 out of range
    sendItem(32'h1111_2222, corrSyn(BLK, 2), 0);
    sendItem(32'h3333_4444, corrSyn(511, 5), 1);
    // R7 single-bit syndromes
    sendItem(32'h0, 24'h000001, 0);
    sendItem(32'hFFFF_FFFF, 24'h001000, 0);
    sendItem(32'h7777_8888, 24'h800000, 0);
    // R8 other nonzero
    sendItem(32'h0, 24'h000003, 0);
    sendItem(32'h0, 24'hFFFFFF, 0);
    sendItem(32'h0, 24'h801000, 2);

    // R9 back-to-back mixed stream
    for (int i = 0; i < 60; i++) begin
      logic [31:0] r;
      logic [23:0] s;
      r = $urandom();
      case (i % 4)
        0: s = 24'h0;
        1: s = corrSyn(int'($urandom_range(0, 511)), int'($urandom_range(0, 7)));
        2: s = 24'd1 << $urandom_range(0, 23);
        default: s = 24'($urandom()) | 24'h000101;
      endcase
      sendItem(r, s, (i % 7 == 0) ? 1 : 0);
    end

    repeat (5) @(negedge clk);
    check("R9 result count", 64'(produced), 64'(sent));
    check("R9 scoreboard empty", 64'(sb.size()), 64'd0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule